// File: doc/BRIEF.md
# Address Window Translation Table

This block turns a 32-bit address issued by a processing core into a request that the on-chip network can deliver. A small writable table, indexed by the top byte of the address, holds one record per 16 MB window. Each record names the on-chip destination (for example the tile that hosts a memory controller), a 3-bit sub-destination, and a 10-bit prefix. The prefix is joined to the 24 untouched low address bits to make a 34-bit system address, so every destination exposes 16 GB, and four memory destinations span 64 GB whether or not that much storage is fitted.

Translation is registered: a request presented with its valid bit gives its result one clock later. A configuration port writes a whole 22-bit record by index in a single cycle and reads any record back. Records that point at register space or an on-chip message buffer are handled exactly like memory records: the block only forwards fields.

Top module: `addr_xlat_table`

## Requirements
- R1: An active-low asynchronous reset clears every record to zero and drives rsp_valid_o, cfg_rvalid_o and all response and read data outputs to zero; a lookup after reset of a never-written record returns destination 0, sub-destination 0 and prefix 0.
- R2: A request accepted on a clock edge (req_valid_i high) selects the record at req_addr_i[31:24]; its result appears after that edge, and rsp_valid_o is high in exactly the cycle after each cycle with req_valid_i high, including back-to-back requests.
- R3: rsp_addr_o[23:0] equals req_addr_i[23:0] of the accepted request.
- R4: rsp_addr_o[33:24] equals record bits [9:0].
- R5: rsp_dest_o equals record bits [20:13]; every 8-bit value is forwarded the same way, none is treated specially.
- R6: rsp_sub_o equals record bits [12:10].
- R7: Record bit 21 has no effect on any response output, but is stored and read back as written.
- R8: With cfg_we_i high, cfg_wdata_i is stored at index cfg_idx_i on that edge; with cfg_re_i high, the record at cfg_idx_i appears on cfg_rdata_o with cfg_rvalid_o high one cycle later.
- R9: When a configuration write and a lookup address the same index on the same edge, the lookup returns the record's previous contents; a lookup on a later edge returns the new value.
- R10: In a cycle after no request was accepted, rsp_dest_o, rsp_sub_o and rsp_addr_o keep their previous values and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_addr_i | input | 32 | Core physical address to translate |
| cfg_we_i | input | 1 | Record write strobe |
| cfg_re_i | input | 1 | Record read strobe |
| cfg_idx_i | input | 8 | Record index for write and read |
| cfg_wdata_i | input | 22 | Record value to write |
| rsp_valid_o | output | 1 | Response valid |
| rsp_dest_o | output | 8 | On-chip routing destination |
| rsp_sub_o | output | 3 | Sub-destination field |
| rsp_addr_o | output | 34 | Extended system address |
| cfg_rvalid_o | output | 1 | Read data valid |
| cfg_rdata_o | output | 22 | Record read back |

## Verification
Records are loaded with all-ones, all-zeros, alternating 01 and 10 patterns, and values that light up only one field, so a field shifted by one bit or swapped with a neighbour shows as a wrong value on a specific output. Low address bits range from zero through all-ones and alternating patterns to separate pass-through from prefix bits, and the indices chosen (0x00, 0x01, 0x7F, 0x80, 0xFF) catch index decoding faults at the ends and middle of the table. A record holding only bit 21 tells whether that bit leaks into the response, and a same-edge write and lookup distinguishes old-value from new-value forwarding.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned RSVD_W  = 1;
  localparam int unsigned DEST_W  = 8;
  localparam int unsigned SUB_W   = 3;
  localparam int unsigned PFX_W   = 10;
  localparam int unsigned PASS_W  = ADDR_W - IDX_W;
  localparam int unsigned ENTRY_W = RSVD_W + DEST_W + SUB_W + PFX_W;
  localparam int unsigned XADDR_W = PFX_W + PASS_W;

  // field order is decoded by software: rsvd at top, prefix at bottom
  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic [DEST_W-1:0] dest;
    logic [SUB_W-1:0]  sub;
    logic [PFX_W-1:0]  pfx;
  } entry_t;
endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
  import xlat_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  entry_t        wdata_i,
  input  logic [IW-1:0] lk_idx_i,
  input  logic [IW-1:0] rd_idx_i,
  output entry_t        lk_entry_o,
  output entry_t        rd_entry_o
);
  localparam int unsigned DEPTH = 1 << IW;

  entry_t rd_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    entry_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (we_i && (widx_i == IW'(g)))   q <= wdata_i;
    end
    assign rd_arr[g] = q;
  end

  // reads see pre-write contents on a colliding edge
  assign lk_entry_o = rd_arr[lk_idx_i];
  assign rd_entry_o = rd_arr[rd_idx_i];

  assert_write_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rd_arr[$past(widx_i)] == $past(wdata_i)));
endmodule

// File: rtl/xlat_lookup_pipe.sv
module xlat_lookup_pipe
  import xlat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [PASS_W-1:0]  pass_i,
  input  entry_t             entry_i,
  output logic               rsp_valid_o,
  output logic [DEST_W-1:0]  dest_o,
  output logic [SUB_W-1:0]   sub_o,
  output logic [XADDR_W-1:0] xaddr_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^entry_i.rsvd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      dest_o      <= '0;
      sub_o       <= '0;
      xaddr_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        dest_o  <= entry_i.dest;
        sub_o   <= entry_i.sub;
        xaddr_o <= {entry_i.pfx, pass_i};
      end
    end
  end

  assert_idle_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(xaddr_o) && $stable(dest_o) && $stable(sub_o)));
endmodule

// File: rtl/addr_xlat_table.sv
module addr_xlat_table
  import xlat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               cfg_we_i,
  input  logic               cfg_re_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [ENTRY_W-1:0] cfg_wdata_i,
  output logic               rsp_valid_o,
  output logic [DEST_W-1:0]  rsp_dest_o,
  output logic [SUB_W-1:0]   rsp_sub_o,
  output logic [XADDR_W-1:0] rsp_addr_o,
  output logic               cfg_rvalid_o,
  output logic [ENTRY_W-1:0] cfg_rdata_o
);
  entry_t lk_entry, rd_entry;

  xlat_entry_store #(.IW(IDX_W)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .widx_i     (cfg_idx_i),
    .wdata_i    (entry_t'(cfg_wdata_i)),
    .lk_idx_i   (req_addr_i[ADDR_W-1 -: IDX_W]),
    .rd_idx_i   (cfg_idx_i),
    .lk_entry_o (lk_entry),
    .rd_entry_o (rd_entry)
  );

  xlat_lookup_pipe i_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .pass_i      (req_addr_i[PASS_W-1:0]),
    .entry_i     (lk_entry),
    .rsp_valid_o (rsp_valid_o),
    .dest_o      (rsp_dest_o),
    .sub_o       (rsp_sub_o),
    .xaddr_o     (rsp_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rvalid_o <= 1'b0;
      cfg_rdata_o  <= '0;
    end else begin
      cfg_rvalid_o <= cfg_re_i;
      if (cfg_re_i) cfg_rdata_o <= rd_entry;
    end
  end

  assert_req_to_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_low_bits_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_addr_o[PASS_W-1:0] == $past(req_addr_i[PASS_W-1:0])));

  assert_read_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_re_i |=> cfg_rvalid_o);
endmodule

// File: tb/test_addr_xlat_table.sv
module test_addr_xlat_table;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i;
  logic [31:0] req_addr_i;
  logic        cfg_we_i, cfg_re_i;
  logic [7:0]  cfg_idx_i;
  logic [21:0] cfg_wdata_i;
  logic        rsp_valid_o, cfg_rvalid_o;
  logic [7:0]  rsp_dest_o;
  logic [2:0]  rsp_sub_o;
  logic [33:0] rsp_addr_o;
  logic [21:0] cfg_rdata_o;

  always #2 clk_i = ~clk_i;

  addr_xlat_table i_addr_xlat_table (.*);

  int n_chk = 0;
  int n_err = 0;

  localparam int NV = 8;
  localparam logic [7:0]  V_IDX [NV] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h10, 8'h20, 8'hA5};
  localparam logic [21:0] V_ENT [NV] = '{22'h3FFFFF, 22'h000001, 22'h155555, 22'h2AAAAA,
                                         22'h1FE000, 22'h001C00, 22'h0003FF, 22'h200000};
  localparam logic [23:0] V_LOW [NV] = '{24'h000000, 24'hFFFFFF, 24'h123456, 24'hABCDEF,
                                         24'h000001, 24'h800000, 24'h7FFFFF, 24'h555555};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_rsp(input string req, input logic [21:0] e, input logic [23:0] low);
    chk({req, " valid"}, 64'(rsp_valid_o), 64'd1);
    chk({req, " dest"},  64'(rsp_dest_o),  64'(e[20:13]));
    chk({req, " sub"},   64'(rsp_sub_o),   64'(e[12:10]));
    chk({req, " addr"},  64'(rsp_addr_o),  64'({e[9:0], low}));
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [21:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_read_chk(input string req, input logic [7:0] idx, input logic [21:0] exp);
    @(negedge clk_i);
    cfg_re_i = 1'b1; cfg_idx_i = idx;
    @(negedge clk_i);
    cfg_re_i = 1'b0;
    chk({req, " rvalid"}, 64'(cfg_rvalid_o), 64'd1);
    chk({req, " rdata"},  64'(cfg_rdata_o),  64'(exp));
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req_valid_i = 1'b0; req_addr_i = '0;
    cfg_we_i = 1'b0; cfg_re_i = 1'b0; cfg_idx_i = '0; cfg_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 rsp_valid",  64'(rsp_valid_o),  64'd0);
    chk("R1 rsp_addr",   64'(rsp_addr_o),   64'd0);
    chk("R1 rsp_dest",   64'(rsp_dest_o),   64'd0);
    chk("R1 cfg_rvalid", 64'(cfg_rvalid_o), 64'd0);
    rst_ni = 1'b1;

    // R1: untouched record is zero
    lookup(32'h33ABCDEF);
    expect_rsp("R1 cleared", 22'h0, 24'hABCDEF);

    // R8: load and read back the vector records
    for (int i = 0; i < NV; i++) cfg_write(V_IDX[i], V_ENT[i]);
    for (int i = 0; i < NV; i++) cfg_read_chk("R8", V_IDX[i], V_ENT[i]);
    cfg_read_chk("R7 stored", 8'hA5, 22'h200000);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < NV; i++) begin
      lookup({V_IDX[i], V_LOW[i]});
      expect_rsp("R2 R3 R4 R5 R6 R7", V_ENT[i], V_LOW[i]);
    end

    // R2: back-to-back requests
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = {V_IDX[2], V_LOW[2]};
    @(negedge clk_i);
    expect_rsp("R2 b2b first", V_ENT[2], V_LOW[2]);
    req_addr_i = {V_IDX[3], V_LOW[3]};
    @(negedge clk_i);
    req_valid_i = 1'b0;
    expect_rsp("R2 b2b second", V_ENT[3], V_LOW[3]);

    // R10: idle cycle holds data, valid drops
    req_addr_i = {V_IDX[0], V_LOW[0]};
    @(negedge clk_i);
    chk("R10 valid low", 64'(rsp_valid_o), 64'd0);
    chk("R10 addr held", 64'(rsp_addr_o), 64'({V_ENT[3][9:0], V_LOW[3]}));
    chk("R10 dest held", 64'(rsp_dest_o), 64'(V_ENT[3][20:13]));

    // R9: same-edge write and lookup
    cfg_write(8'h40, 22'h0ABCDE);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 8'h40; cfg_wdata_i = 22'h1F0F0F;
    req_valid_i = 1'b1; req_addr_i = 32'h40000123;
    @(negedge clk_i);
    cfg_we_i = 1'b0; req_valid_i = 1'b0;
    expect_rsp("R9 old value", 22'h0ABCDE, 24'h000123);
    lookup(32'h40000123);
    expect_rsp("R9 new value", 22'h1F0F0F, 24'h000123);

    // R1: reset mid-run clears records
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 mid valid", 64'(rsp_valid_o), 64'd0);
    chk("R1 mid addr",  64'(rsp_addr_o),  64'd0);
    rst_ni = 1'b1;
    cfg_read_chk("R1 mid record", V_IDX[0], 22'h0);

    summary();
    $finish;
  end
endmodule